// File: doc/BRIEF.md
# Frame-Synchronous Ping-Pong Coefficient Store

This block holds the coefficients of a running audio processing pipeline in two complete banks. At any moment one bank is live and answers coefficient reads from the datapath. The other bank is a shadow that the host may rewrite freely. Because the live bank is never touched by the host, coefficients can be changed while audio keeps flowing, with no mute and no shutdown.

To publish new coefficients, the host sets a swap request bit in a paged control register. The block looks at that bit only on the frame boundary strobe. If the bit is set there, the two banks trade roles and the request bit clears on the same clock edge. During configuration the host can write one value into both banks at once, so that the first exchange changes nothing audible. A read-only status bit in the same register shows which bank is live, so the host can tell when an exchange has taken effect.

Top module: `coef_pingpong`

## Requirements
- R1: After reset, bank A is live, the request bit is 0 and the control register reads 0x00.
- R2: The datapath read port returns the live bank's word at `rd_addr` on the clock edge after the address is presented (one-cycle latency).
- R3: A coefficient write with `coef_mirror` low updates only the shadow bank. Live-bank reads keep returning the old value until an exchange occurs.
- R4: A coefficient write with `coef_mirror` high stores the same word at the same address in both banks.
- R5: The control register is at page 44, register 1. Bit 0 is the read/write swap request. Bit 1 is the read-only live-bank flag (0 = A, 1 = B), and writes to bit 1 have no effect. Writing 0 to bit 0 withdraws a pending request. Every other page/register reads 0x00.
- R6: A pending request causes no exchange until `frame_end` is high at a clock edge.
- R7: At a clock edge with `frame_end` high and the request bit set, the live bank toggles and the request bit clears on that same edge.
- R8: A write of 1 to the request bit on the same edge as `frame_end` is kept as pending for the next frame. This holds whether or not an exchange happens on that edge.
- R9: Register writes to any page/register other than the control register leave the request bit and the live bank unchanged.
- R10: At a clock edge with `frame_end` high and the request bit clear, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end | input | 1 | One-cycle strobe marking the end of an audio frame |
| rd_addr | input | AW | Datapath coefficient address |
| rd_data | output | CW | Live-bank coefficient, one cycle after the address |
| coef_we | input | 1 | Host coefficient write strobe |
| coef_mirror | input | 1 | Write goes to both banks (configuration) |
| coef_addr | input | AW | Host coefficient address |
| coef_wdata | input | CW | Host coefficient data |
| reg_we | input | 1 | Control register write strobe |
| reg_page | input | 8 | Register page select |
| reg_addr | input | 8 | Register index within the page |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Writes, swap requests and the exchange all take effect on the first rising edge after they are driven. The bench therefore drives every input on a falling edge and checks one falling edge later. Register readback is combinational, so the bench samples it shortly after the page and index are set. Coefficient reads are sampled one full cycle after the address is applied, matching the one-cycle read latency. The collision cases drive `frame_end` and the register write in the same half-cycle, so both land on the same edge.

// File: rtl/coef_pingpong.sv
module coef_pingpong #(
  parameter int CW        = 24,
  parameter int DEPTH     = 16,
  parameter int SWAP_PAGE = 44,
  parameter int SWAP_REG  = 1,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          coef_we,
  input  logic          coef_mirror,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_wdata,
  input  logic          reg_we,
  input  logic [7:0]    reg_page,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);

  logic [CW-1:0] bank_a [DEPTH];
  logic [CW-1:0] bank_b [DEPTH];
  logic          live_b;
  logic          req_q;

  wire ctl_sel  = (reg_page == 8'(SWAP_PAGE)) && (reg_addr == 8'(SWAP_REG));
  wire ctl_wr   = reg_we && ctl_sel;
  wire do_swap  = frame_end && req_q;

  assign reg_rdata = ctl_sel ? {6'd0, live_b, req_q} : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_b <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (do_swap) live_b <= ~live_b;
      if (ctl_wr)       req_q <= reg_wdata[0];
      else if (do_swap) req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (coef_we && (coef_mirror || live_b))  bank_a[coef_addr] <= coef_wdata;
    if (coef_we && (coef_mirror || !live_b)) bank_b[coef_addr] <= coef_wdata;
    rd_data <= live_b ? bank_b[rd_addr] : bank_a[rd_addr];
  end

endmodule

module coef_pingpong_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_end,
  input logic live,
  input logic req,
  input logic set_hit,
  input logic set_val
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!live && !req));

  p_hold_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (live == $past(live)));

  p_swap_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && req) |=> (live != $past(live)));

  p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && req && !set_hit) |=> !req);

  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && set_val) |=> req);

  p_idle_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !req) |=> $stable(live));

endmodule

bind coef_pingpong coef_pingpong_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
  .live(live_b), .req(req_q), .set_hit(ctl_wr), .set_val(reg_wdata[0])
);

// File: tb/coef_pingpong_bench.sv
module coef_pingpong_bench;
  localparam int CW = 24;
  localparam int AW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          frame_end = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          coef_we = 0, coef_mirror = 0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_wdata = '0;
  logic          reg_we = 0;
  logic [7:0]    reg_page = 8'd44, reg_addr = 8'd1, reg_wdata = 0;
  logic [7:0]    reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  coef_pingpong u_coef_pingpong (.*);

  always #10 clk = ~clk;

  function automatic logic [CW-1:0] mval(int i);
    return 24'h100000 + 24'(i) * 24'h001011;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic coef_wr(int a, logic [CW-1:0] d, bit both);
    @(negedge clk);
    coef_we = 1; coef_mirror = both; coef_addr = AW'(a); coef_wdata = d;
    @(negedge clk);
    coef_we = 0; coef_mirror = 0;
  endtask

  task automatic coef_chk(string req, int a, logic [CW-1:0] exp);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic reg_wr(int pg, int ad, logic [7:0] d, bit with_frame);
    @(negedge clk);
    reg_we = 1; reg_page = 8'(pg); reg_addr = 8'(ad); reg_wdata = d;
    frame_end = with_frame;
    @(negedge clk);
    reg_we = 0; frame_end = 0; reg_page = 8'd44; reg_addr = 8'd1;
  endtask

  task automatic reg_chk(string req, int pg, int ad, logic [7:0] exp);
    reg_page = 8'(pg); reg_addr = 8'(ad);
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
    reg_page = 8'd44; reg_addr = 8'd1;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
  endtask

  task automatic t_reset();
    reg_chk("R1", 44, 1, 8'h00);
  endtask

  task automatic t_mirror_load();
    for (int i = 0; i < 4; i++) coef_wr(i, mval(i), 1);
    for (int i = 0; i < 4; i++) coef_chk("R4/R2 bank A", i, mval(i));
  endtask

  task automatic t_shadow_write();
    coef_wr(1, 24'hABCDEF, 0);
    coef_chk("R3 live unchanged", 1, mval(1));
  endtask

  task automatic t_deferred();
    reg_wr(44, 1, 8'h01, 0);
    reg_chk("R5 request readback", 44, 1, 8'h01);
    repeat (6) @(negedge clk);
    reg_chk("R6 no swap before frame end", 44, 1, 8'h01);
    coef_chk("R6 still bank A", 1, mval(1));
  endtask

  task automatic t_swap();
    frame_pulse();
    reg_chk("R7 toggled and cleared", 44, 1, 8'h02);
    coef_chk("R7 new word live", 1, 24'hABCDEF);
    coef_chk("R4 bank B mirror", 2, mval(2));
  endtask

  task automatic t_idle_frame();
    frame_pulse();
    reg_chk("R10 idle frame", 44, 1, 8'h02);
  endtask

  task automatic t_status_ro();
    reg_wr(44, 1, 8'h00, 0);
    reg_chk("R5 bit1 read-only", 44, 1, 8'h02);
    reg_wr(44, 1, 8'h03, 0);
    reg_chk("R5 set with bit1", 44, 1, 8'h03);
    reg_wr(44, 1, 8'h00, 0);
    reg_chk("R5 withdraw", 44, 1, 8'h02);
    frame_pulse();
    reg_chk("R5 withdrawn no swap", 44, 1, 8'h02);
  endtask

  task automatic t_other_regs();
    reg_wr(44, 2, 8'hFF, 0);
    reg_wr(43, 1, 8'hFF, 0);
    reg_chk("R9 foreign writes", 44, 1, 8'h02);
    reg_chk("R5 foreign read zero", 43, 1, 8'h00);
    frame_pulse();
    reg_chk("R9 still no swap", 44, 1, 8'h02);
  endtask

  task automatic t_collide();
    reg_wr(44, 1, 8'h01, 1);
    reg_chk("R8 kept, no swap", 44, 1, 8'h03);
    reg_wr(44, 1, 8'h01, 1);
    reg_chk("R8 swap and kept", 44, 1, 8'h01);
    frame_pulse();
    reg_chk("R7 pending served", 44, 1, 8'h02);
  endtask

  task automatic t_shadow_a();
    coef_wr(2, 24'h123456, 0);
    coef_chk("R3 live B unchanged", 2, mval(2));
    reg_wr(44, 1, 8'h01, 0);
    frame_pulse();
    reg_chk("R7 back to A", 44, 1, 8'h00);
    coef_chk("R3 A update live", 2, 24'h123456);
    coef_chk("R2 A untouched word", 1, mval(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mirror_load();
    t_shadow_write();
    t_deferred();
    t_swap();
    t_idle_frame();
    t_status_ro();
    t_other_regs();
    t_collide();
    t_shadow_a();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule